// File: doc/BRIEF.md
# SPI Master with Register Interface

This block is a single-channel SPI master, controlled through a small set of 32-bit registers on a simple synchronous bus. The bus has a select, a write strobe, a byte address, write data and combinational read data. Software uses the registers to choose one of eight active-low chip-select lines and to set the clock polarity and phase. It also sets the bit order for each direction, the serial clock divider and a delay for sampling MISO. Writing a byte to the transmit register starts one 8-bit exchange.

While the exchange runs, a busy bit is set. When the exchange is done, a completion flag is set and the received byte can be read from the receive register. Software clears the completion flag by writing zero to it. A write to the transmit register during an exchange is ignored. The chip-select outputs are set directly by software and are independent of the exchange, so several bytes can be framed under one select.

Top module: `spi_host_ctl`

## Requirements
- R1: Register map, with byte offsets.
  - 0x00 control: bit 0 is the select enable; bits 4:2 are the select index.
  - 0x04 configuration: bits 14:11 and 7:0 are writable; all other bits read as 0.
  - 0x08 transmit byte.
  - 0x0C receive byte.
  - 0x10 status: bit 0 is the completion flag; bit 1 is busy.
  - 0x18 timing: bits 7:6 are the sample delay; all other bits read as 0.
  - After reset, every register reads 0 except timing, which reads 0x80 (delay 2).
- R2: `spi_cs_n[i]` is low exactly when the enable bit is 1 and the index equals i. All other lines are high. The outputs change on the clock edge that takes the control write.
- R3: The divide ratio is N = S × 2^E. S is configuration bits 3:0. E is {configuration bits 7:6, configuration bit 4}, with bit 4 as the least significant bit. For N ≥ 2, one SCLK period is N core cycles: the first half lasts floor(N/2) cycles and the second half lasts the remainder. For N = 1 the period is 2 cycles.
- R4: A transmit write while idle starts an exchange of exactly 16 SCLK edges. Status bit 1 reads 1 from the cycle after the write until the exchange completes.
- R5: When idle, SCLK equals CPOL (configuration bit 11). With CPHA (bit 12) = 0, MISO is sampled on leading edges and MOSI changes on trailing edges, and the first bit is driven before the first edge. With CPHA = 1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R6: Configuration bit 13 = 1 sends transmit bit 0 first. When it is 0, bit 7 is sent first.
- R7: Configuration bit 14 = 1 places the first received bit in bit 0. When it is 0, the first received bit goes to bit 7. The receive register holds the byte of the last completed exchange.
- R8: With D the timing delay, MISO is captured D core cycles after each sampling edge. If a transmit write is taken at clock edge t, the completion flag and the cleared busy bit are visible after edge t + 8·P + D + 1, where P is the SCLK period from R3.
- R9: The completion flag is set when an exchange completes. A status write with bit 0 = 0 clears the flag. If completion and a clearing write fall on the same edge, the flag ends up set.
- R10: A transmit write while busy has no effect: the transmitted byte, the transmit readback and the completion time are unchanged.
- R11: S = 0 is treated as S = 1, so N = 2^E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 8 | Active-low chip selects |

## Verification
The critical overlap is an exchange completing on the same clock edge as a software write that clears the completion flag. The bench computes the exact completion edge from R8. It then places a zero-write to the status register on that edge, and a second one on the edge after it. It judges the result by reading the flag back: the flag must remain set after the first write and be cleared by the second. A transmit write issued in the middle of an exchange is covered as a second overlap. That case is judged by the byte the slave model received, the transmit readback and an unchanged completion time.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int BYTE_W  = 8;
  localparam int PRESC_W = 4;
  localparam int EXP_W   = 3;
  localparam int DIV_W   = PRESC_W + (1 << EXP_W) - 1;
  localparam int DLY_W   = 2;
  localparam int CS_N    = 8;
  localparam int CSI_W   = $clog2(CS_N);
  localparam int EDGES   = 2 * BYTE_W;
  localparam int ECNT_W  = $clog2(EDGES + 1);
  localparam int BIDX_W  = $clog2(BYTE_W);
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] A_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] A_CFG   = 5'h04;
  localparam logic [ADDR_W-1:0] A_TXB   = 5'h08;
  localparam logic [ADDR_W-1:0] A_RXB   = 5'h0C;
  localparam logic [ADDR_W-1:0] A_STAT  = 5'h10;
  localparam logic [ADDR_W-1:0] A_TMG   = 5'h18;

  localparam logic [14:0] CFG_MASK = 15'h78FF;

  // Divide ratio: prescale (zero treated as one) times power of two.
  function automatic logic [DIV_W-1:0] div_ratio(input logic [PRESC_W-1:0] spr,
                                                  input logic [EXP_W-1:0] sppr);
    logic [DIV_W-1:0] base;
    base = (spr == '0) ? DIV_W'(1) : DIV_W'(spr);
    return base << sppr;
  endfunction

  // Length of first (second=0) or second half of an SCLK period.
  function automatic logic [DIV_W-1:0] half_len(input logic [DIV_W-1:0] n,
                                                 input logic second);
    logic [DIV_W-1:0] h1;
    h1 = n >> 1;
    if (h1 == '0) h1 = DIV_W'(1);
    if (!second) return h1;
    return (n > h1) ? (n - h1) : DIV_W'(1);
  endfunction

  // Which transmit bit (in send order) is on MOSI after a number of edges.
  function automatic logic [BIDX_W-1:0] mosi_index(input logic [ECNT_W-1:0] edges,
                                                    input logic cpha);
    logic [ECNT_W-1:0] k;
    k = (cpha && edges != '0) ? edges - ECNT_W'(1) : edges;
    k = k >> 1;
    return (k > ECNT_W'(BYTE_W - 1)) ? BIDX_W'(BYTE_W - 1) : k[BIDX_W-1:0];
  endfunction
endpackage

// File: rtl/spi_host_baud.sv
module spi_host_baud
  import spi_host_pkg::*;
#(
  parameter int P_W = PRESC_W,
  parameter int E_W = EXP_W,
  parameter int D_W = DIV_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           run,
  input  logic [P_W-1:0] spr,
  input  logic [E_W-1:0] sppr,
  output logic           edge_tick
);
  logic [D_W-1:0] cnt_q;
  logic           half_q;
  logic [D_W-1:0] limit;

  assign limit     = half_len(div_ratio(spr, sppr), half_q) - D_W'(1);
  assign edge_tick = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (run) begin
      if (edge_tick) begin
        cnt_q  <= '0;
        half_q <= ~half_q;
      end else begin
        cnt_q <= cnt_q + D_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
  import spi_host_pkg::*;
#(
  parameter int B_W  = BYTE_W,
  parameter int DL_W = DLY_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [B_W-1:0]  tx_byte,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            tx_lsb,
  input  logic            rx_lsb,
  input  logic [DL_W-1:0] dly,
  input  logic            edge_tick,
  input  logic            miso,
  output logic            busy,
  output logic            running,
  output logic            done,
  output logic            sample_ev,
  output logic            capture_ev,
  output logic [B_W-1:0]  rx_byte,
  output logic            sclk,
  output logic            mosi
);
  localparam int PEND_W = (1 << DL_W) - 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} eng_st_t;

  eng_st_t           st_q;
  logic [ECNT_W-1:0] edges_q;
  logic              phase_q;
  logic [PEND_W-1:0] pend_q;
  logic [PEND_W:0]   pend_all;
  logic [DL_W-1:0]   tail_q;
  logic [B_W-1:0]    rx_sh_q;
  logic [B_W-1:0]    rx_hold_q;
  logic              last_edge;
  logic [BIDX_W-1:0] idx;

  assign running    = (st_q == ST_RUN);
  assign busy       = (st_q != ST_IDLE);
  assign sample_ev  = running && edge_tick && (edges_q[0] == cpha);
  assign last_edge  = running && edge_tick && (edges_q == ECNT_W'(EDGES - 1));
  assign pend_all   = {pend_q, sample_ev};
  assign capture_ev = pend_all[dly];
  assign done       = (st_q == ST_TAIL) && (tail_q == '0);
  assign sclk       = cpol ^ phase_q;
  assign idx        = mosi_index(edges_q, cpha);
  assign mosi       = tx_byte[tx_lsb ? idx : BIDX_W'(B_W - 1) - idx];
  assign rx_byte    = rx_hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      edges_q   <= '0;
      phase_q   <= 1'b0;
      pend_q    <= '0;
      tail_q    <= '0;
      rx_sh_q   <= '0;
      rx_hold_q <= '0;
    end else begin
      pend_q <= start ? '0 : pend_all[PEND_W-1:0];
      if (capture_ev)
        rx_sh_q <= rx_lsb ? {miso, rx_sh_q[B_W-1:1]} : {rx_sh_q[B_W-2:0], miso};
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q    <= ST_RUN;
          edges_q <= '0;
          phase_q <= 1'b0;
        end
        ST_RUN: if (edge_tick) begin
          phase_q <= ~phase_q;
          edges_q <= edges_q + ECNT_W'(1);
          if (last_edge) begin
            st_q   <= ST_TAIL;
            tail_q <= dly;
          end
        end
        ST_TAIL: if (tail_q == '0) begin
          st_q      <= ST_IDLE;
          rx_hold_q <= rx_sh_q;
        end else begin
          tail_q <= tail_q - DL_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int A_W = ADDR_W,
  parameter int W   = DATA_W,
  parameter int NCS = CS_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [A_W-1:0]    bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              start,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [PRESC_W-1:0] spr,
  output logic [EXP_W-1:0]  sppr,
  output logic              cpol,
  output logic              cpha,
  output logic              tx_lsb,
  output logic              rx_lsb,
  output logic [DLY_W-1:0]  dly,
  output logic              flag,
  output logic [NCS-1:0]    cs_n
);
  logic              en_q;
  logic [CSI_W-1:0]  csi_q;
  logic [14:0]       cfg_q;
  logic [DLY_W-1:0]  dly_q;
  logic [BYTE_W-1:0] tx_q;
  logic              flag_q;
  logic [NCS-1:0]    cs_n_q;
  logic [NCS-1:0]    cs_next;
  logic              wr;

  assign wr    = bus_sel && bus_wr;
  assign start = wr && (bus_addr == A_TXB) && !busy;

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_next[i] = !(bus_wdata[0] && (bus_wdata[2 +: CSI_W] == CSI_W'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      csi_q  <= '0;
      cfg_q  <= '0;
      dly_q  <= DLY_W'(2);
      tx_q   <= '0;
      flag_q <= 1'b0;
      cs_n_q <= '1;
    end else begin
      if (wr && bus_addr == A_CTRL) begin
        en_q   <= bus_wdata[0];
        csi_q  <= bus_wdata[2 +: CSI_W];
        cs_n_q <= cs_next;
      end
      if (wr && bus_addr == A_CFG) cfg_q <= bus_wdata[14:0] & CFG_MASK;
      if (wr && bus_addr == A_TMG) dly_q <= bus_wdata[6 +: DLY_W];
      if (start) tx_q <= bus_wdata[BYTE_W-1:0];
      if (done) flag_q <= 1'b1;
      else if (wr && bus_addr == A_STAT && !bus_wdata[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL: bus_rdata = W'({csi_q, 1'b0, en_q});
      A_CFG:  bus_rdata = W'(cfg_q);
      A_TXB:  bus_rdata = W'(tx_q);
      A_RXB:  bus_rdata = W'(rx_byte);
      A_STAT: bus_rdata = W'({busy, flag_q});
      A_TMG:  bus_rdata = W'({dly_q, 6'd0});
      default: bus_rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[W-1:15], bus_wdata[1]};

  assign tx_byte = tx_q;
  assign spr     = cfg_q[3:0];
  assign sppr    = {cfg_q[7:6], cfg_q[4]};
  assign cpol    = cfg_q[11];
  assign cpha    = cfg_q[12];
  assign tx_lsb  = cfg_q[13];
  assign rx_lsb  = cfg_q[14];
  assign dly     = dly_q;
  assign flag    = flag_q;
  assign cs_n    = cs_n_q;
endmodule

// File: rtl/spi_host_ctl.sv
module spi_host_ctl
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [CS_N-1:0]   spi_cs_n
);
  logic               start_w, busy_w, running_w, done_w, edge_w;
  logic               sample_w, capture_w, flag_w;
  logic [BYTE_W-1:0]  tx_w, rx_w;
  logic [PRESC_W-1:0] spr_w;
  logic [EXP_W-1:0]   sppr_w;
  logic               cpol_w, cpha_w, txl_w, rxl_w;
  logic [DLY_W-1:0]   dly_w;

  spi_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy_w), .done(done_w), .rx_byte(rx_w), .start(start_w),
    .tx_byte(tx_w), .spr(spr_w), .sppr(sppr_w), .cpol(cpol_w), .cpha(cpha_w),
    .tx_lsb(txl_w), .rx_lsb(rxl_w), .dly(dly_w), .flag(flag_w), .cs_n(spi_cs_n)
  );

  spi_host_baud u_baud (
    .clk(clk), .rst_n(rst_n), .restart(start_w), .run(running_w),
    .spr(spr_w), .sppr(sppr_w), .edge_tick(edge_w)
  );

  spi_host_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_w), .tx_byte(tx_w),
    .cpol(cpol_w), .cpha(cpha_w), .tx_lsb(txl_w), .rx_lsb(rxl_w),
    .dly(dly_w), .edge_tick(edge_w), .miso(spi_miso), .busy(busy_w),
    .running(running_w), .done(done_w), .sample_ev(sample_w),
    .capture_ev(capture_w), .rx_byte(rx_w), .sclk(spi_sclk), .mosi(spi_mosi)
  );
endmodule

// File: rtl/spi_host_ctl_chk.sv
module spi_host_ctl_chk
  import spi_host_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              start_w,
  input logic              busy_w,
  input logic              done_w,
  input logic              edge_w,
  input logic              flag_w,
  input logic              cpol_w,
  input logic              sclk,
  input logic [BYTE_W-1:0] tx_w,
  input logic [CS_N-1:0]   cs_n
);
  logic wr_tx, wr_clr;
  logic [ECNT_W:0] ecnt_q;

  assign wr_tx  = bus_sel && bus_wr && (bus_addr == A_TXB);
  assign wr_clr = bus_sel && bus_wr && (bus_addr == A_STAT) && !bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ecnt_q <= '0;
    else if (start_w) ecnt_q <= '0;
    else if (edge_w)  ecnt_q <= ecnt_q + 1'b1;
  end

  // R2
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> sclk == cpol_w);

  // R4
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |-> !busy_w);

  // R4
  edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |-> ecnt_q == (ECNT_W+1)'(EDGES));

  // R9
  done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> (flag_w && !busy_w));

  // R9
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !done_w) |=> !flag_w);

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && busy_w) |=> $stable(tx_w));
endmodule

bind spi_host_ctl spi_host_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .start_w(start_w),
  .busy_w(busy_w), .done_w(done_w), .edge_w(edge_w), .flag_w(flag_w),
  .cpol_w(cpol_w), .sclk(spi_sclk), .tx_w(tx_w), .cs_n(spi_cs_n)
);

// File: tb/spi_host_ctl_bench.sv
module spi_host_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi;
  logic        miso = 1'b0;
  logic [7:0]  cs_n;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  spi_host_ctl u_spi_host_ctl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
  );

  always #5 clk = ~clk;

  // Slave model: MSB first on both lines.
  logic [7:0] slave_tx = '0, slave_rx = '0;
  logic       cpol_m = 1'b0, cpha_m = 1'b0;
  logic [2:0] csi_m = '0;
  int         slave_bit = 0;
  logic       sclk_prev = 1'b0, sel_prev = 1'b1;
  wire        sel_n = cs_n[csi_m];

  always @(sclk or sel_n) begin
    if (sel_prev === 1'b1 && sel_n === 1'b0) begin
      slave_bit = 0;
      slave_rx  = '0;
      if (!cpha_m) miso = slave_tx[7];
    end else if (sel_n === 1'b0 && sclk !== sclk_prev) begin
      if ((sclk !== cpol_m) == !cpha_m) begin
        slave_rx = {slave_rx[6:0], mosi};
      end else if (!cpha_m) begin
        slave_bit++;
        if (slave_bit < 8) miso = slave_tx[7 - slave_bit];
      end else begin
        if (slave_bit < 8) miso = slave_tx[7 - slave_bit];
        slave_bit++;
      end
    end
    sclk_prev = sclk;
    sel_prev  = sel_n;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic [7:0] flip(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7 - i];
    return r;
  endfunction

  function automatic int period(input int spr, input int sppr);
    int n;
    n = ((spr == 0) ? 1 : spr) * (1 << sppr);
    return (n < 2) ? 2 : n;
  endfunction

  function automatic logic [31:0] cfg_word(input logic pol, pha, txl, rxl,
                                           input logic [3:0] spr, input logic [2:0] sppr);
    return {17'd0, rxl, txl, pha, pol, 3'd0, sppr[2:1], 1'b0, sppr[0], spr};
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(5'h00, d); chk("R1 ctrl reset", d, 32'h0);
    rd(5'h04, d); chk("R1 cfg reset", d, 32'h0);
    rd(5'h18, d); chk("R1 timing reset", d, 32'h80);
    rd(5'h10, d); chk("R9 status reset", d, 32'h0);
    chk("R2 cs reset", {24'd0, cs_n}, 32'hFF);
    chk("R5 sclk reset", {31'd0, sclk}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, d); chk("R1 cfg mask", d, 32'h0000_78FF);
    wr(5'h18, 32'hFFFF_FFFF); rd(5'h18, d); chk("R1 timing mask", d, 32'hC0);
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, d); chk("R1 ctrl mask", d, 32'h1D);
    wr(5'h04, 32'h0);
    for (int i = 0; i < 8; i++) begin
      wr(5'h00, {27'd0, i[2:0], 2'b01});
      chk("R2 cs decode", {24'd0, cs_n}, {24'd0, ~(8'd1 << i)});
    end
    wr(5'h00, 32'h14);
    chk("R2 cs disabled", {24'd0, cs_n}, 32'hFF);
  endtask

  task automatic run_xfer(input string tag, input logic pol, pha, txl, rxl,
                          input logic [3:0] spr, input logic [2:0] sppr,
                          input logic [1:0] dly, input logic [7:0] tx, resp,
                          input logic [2:0] csi);
    logic [31:0] d;
    int lat, exp_lat;
    cpol_m = pol; cpha_m = pha; csi_m = csi;
    wr(5'h04, cfg_word(pol, pha, txl, rxl, spr, sppr));
    chk({tag, " R5 idle level"}, {31'd0, sclk}, {31'd0, pol});
    wr(5'h18, {24'd0, dly, 6'd0});
    slave_tx = resp;
    wr(5'h00, {27'd0, csi, 2'b01});
    wr(5'h08, {24'd0, tx});
    lat = 0; d = '0;
    while (d[0] !== 1'b1 && lat < 5000) begin
      @(posedge clk); #1; lat++;
      rd(5'h10, d);
    end
    exp_lat = 8 * period(spr, sppr) + dly + 1;
    chk({tag, " R8 R3 latency"}, lat, exp_lat);
    chk({tag, " R4 status done"}, d, 32'h1);
    rd(5'h0C, d);
    chk({tag, " R7 rx byte"}, d, {24'd0, rxl ? flip(resp) : resp});
    chk({tag, " R6 slave got"}, {24'd0, slave_rx}, {24'd0, txl ? flip(tx) : tx});
    wr(5'h10, 32'h0); rd(5'h10, d);
    chk({tag, " R9 cleared"}, d, 32'h0);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_modes;
    run_xfer("mode0", 0, 0, 0, 0, 4'd4, 3'd0, 2'd0, 8'hA5, 8'h3C, 3'd0);
    run_xfer("mode1", 0, 1, 1, 0, 4'd3, 3'd1, 2'd1, 8'h81, 8'h5A, 3'd3);
    run_xfer("mode2", 1, 0, 0, 1, 4'd1, 3'd3, 2'd2, 8'h6B, 8'hC1, 3'd5);
    run_xfer("mode3", 1, 1, 1, 1, 4'd15, 3'd0, 2'd3, 8'h0F, 8'hE7, 3'd7);
    run_xfer("odd3",  0, 1, 0, 0, 4'd3, 3'd0, 2'd0, 8'h4E, 8'h92, 3'd1);
  endtask

  task automatic t_spr_zero;
    run_xfer("R11 n1", 0, 0, 0, 0, 4'd0, 3'd0, 2'd0, 8'h96, 8'h69, 3'd2);
    run_xfer("R11 n4", 1, 1, 0, 0, 4'd0, 3'd2, 2'd0, 8'hC3, 8'h1E, 3'd4);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] d;
    int lat;
    cpol_m = 0; cpha_m = 0; csi_m = 3'd6;
    wr(5'h04, cfg_word(0, 0, 0, 0, 4'd8, 3'd0));
    wr(5'h18, 32'h0);
    slave_tx = 8'h77;
    wr(5'h00, {27'd0, 3'd6, 2'b01});
    wr(5'h08, 32'hA5);
    repeat (10) @(posedge clk);
    #1; rd(5'h10, d); chk("R4 busy bit", d, 32'h2);
    wr(5'h08, 32'h3C);
    lat = 11;
    rd(5'h08, d); chk("R10 tx readback", d, 32'hA5);
    d = '0;
    while (d[0] !== 1'b1 && lat < 5000) begin
      @(posedge clk); #1; lat++;
      rd(5'h10, d);
    end
    chk("R10 latency kept", lat, 8 * 8 + 0 + 1);
    chk("R10 slave got", {24'd0, slave_rx}, 32'hA5);
    rd(5'h0C, d); chk("R10 rx byte", d, 32'h77);
    wr(5'h10, 32'h0);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    int l;
    cpol_m = 0; cpha_m = 0; csi_m = 3'd0;
    wr(5'h04, cfg_word(0, 0, 0, 0, 4'd2, 3'd0));
    wr(5'h18, 32'h40);
    slave_tx = 8'h55;
    wr(5'h00, 32'h1);
    l = 8 * 2 + 1 + 1;
    wr(5'h08, 32'hAA);
    repeat (l - 1) @(posedge clk);
    #1; rd(5'h10, d); chk("R9 before completion", d, 32'h2);
    wr(5'h10, 32'h0);
    rd(5'h10, d); chk("R9 set wins collision", d, 32'h1);
    wr(5'h10, 32'h0);
    rd(5'h10, d); chk("R9 next clear", d, 32'h0);
    wr(5'h00, 32'h0);
  endtask

  initial begin
    #(150000 * 10);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset;
    t_regs;
    t_modes;
    t_spr_zero;
    t_busy_ignore;
    t_collide;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule